// File: doc/BRIEF.md
# Three-Digit Sequential Door Lock

This block is a clocked door lock. It takes code digits one at a time and opens only when three digits in a row match a combination fixed at build time. A one-cycle strobe marks each entered digit. Each strobe consumes one entry. A wrong digit at any step sends the lock into a closed error state, and only a reset clears it. Once the lock is open it stays open until reset.

Inside, a datapath holds the three combination values. A one-hot multiplexer picks the value expected at the current step, and an equality comparator checks it against the entered digit. A controller with five states steps through the sequence. The state code is chosen so that the multiplexer select is the three low state bits and the open signal is the top state bit. Neither output passes through any decoding.

Top module: `seq_door_lock`

## Requirements
- R1: While rst_ni is low, and after it returns high with no entries yet, the lock is in the first-digit step: open_o = 0 and step_sel_o = 3'b001.
- R2: step_sel_o is one-hot and names the expected digit: 3'b001 for the first (CODE_A), 3'b010 for the second (CODE_B), 3'b100 for the third (CODE_C). It is 3'b000 in the open and error states.
- R3: In a cycle where new_i is low, the state, and so both outputs, does not change.
- R4: In a digit step, a strobed entry equal to the expected value advances to the next step on the following clock edge. With the defaults, the sequence is 3, 4, 2.
- R5: In a digit step, a strobed entry that differs from the expected value moves to the error state: open_o = 0 and step_sel_o = 3'b000. Further entries are ignored until reset.
- R6: A matching third digit opens the lock: open_o = 1 and step_sel_o = 3'b000. The lock stays open through further entries until reset.
- R7: Both outputs come straight from state flops. A change on value_i or new_i has no effect on them before the next rising clock edge.
- R8: The 4-bit state is always one of the five legal codes: 0001, 0010, 0100, 1000 or 0000. Any other code falls back to the error code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; inputs are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low; returns the lock to the first-digit step |
| new_i | input | 1 | One-cycle strobe marking a valid entry on value_i |
| value_i | input | DIGIT_W (4) | Entered code digit |
| open_o | output | 1 | 1 = door open, 0 = closed |
| step_sel_o | output | 3 | One-hot select of the expected combination digit |

## Verification
On every cycle, the assertions check four things: the state stays within the five legal codes, the machine holds when no strobe arrives, the open and error states are sticky, and the comparator result maps onto the correct next state. The bench sweeps every 4-bit value at each of the three steps, each time after a correct prefix. This shows the exact digit sequence that opens the lock, and that a wrong digit at any position locks it out. Only these scenarios can show the reset state, that outputs do not respond combinationally to inputs, and that entries are ignored after opening or after an error.

// File: rtl/lock_pkg.sv
package lock_pkg;
  // low three bits double as digit select, top bit as open flag
  typedef enum logic [3:0] {
    ST_ERR  = 4'b0000,
    ST_D1   = 4'b0001,
    ST_D2   = 4'b0010,
    ST_D3   = 4'b0100,
    ST_OPEN = 4'b1000
  } lock_state_e;

  localparam int unsigned NUM_STEPS = 3;
endpackage

// File: rtl/code_select.sv
module code_select #(
  parameter int unsigned DIGIT_W = 4,
  parameter logic [DIGIT_W-1:0] CODE_A = 3,
  parameter logic [DIGIT_W-1:0] CODE_B = 4,
  parameter logic [DIGIT_W-1:0] CODE_C = 2
) (
  input  logic [lock_pkg::NUM_STEPS-1:0] sel_i,
  output logic [DIGIT_W-1:0]             code_o
);
  localparam int unsigned N = lock_pkg::NUM_STEPS;

  logic [DIGIT_W-1:0] codes  [N];
  logic [DIGIT_W-1:0] masked [N];

  assign codes[0] = CODE_A;
  assign codes[1] = CODE_B;
  assign codes[2] = CODE_C;

  // AND-OR mux, one-hot select
  for (genvar g = 0; g < N; g++) begin : g_mask
    assign masked[g] = codes[g] & {DIGIT_W{sel_i[g]}};
  end

  always_comb begin
    code_o = '0;
    for (int i = 0; i < N; i++) code_o = code_o | masked[i];
  end
endmodule

// File: rtl/code_match.sv
module code_match #(
  parameter int unsigned DIGIT_W = 4
) (
  input  logic [DIGIT_W-1:0] entry_i,
  input  logic [DIGIT_W-1:0] expect_i,
  output logic               eq_o
);
  assign eq_o = (entry_i == expect_i);
endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl
  import lock_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        new_i,
  input  logic        match_i,
  output lock_state_e state_o
);
  lock_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_D1:   if (new_i) state_d = match_i ? ST_D2   : ST_ERR;
      ST_D2:   if (new_i) state_d = match_i ? ST_D3   : ST_ERR;
      ST_D3:   if (new_i) state_d = match_i ? ST_OPEN : ST_ERR;
      ST_OPEN: state_d = ST_OPEN;
      ST_ERR:  state_d = ST_ERR;
      default: state_d = ST_ERR;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_D1;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  assert_legal_code_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(state_q));

  assert_hold_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !new_i |=> $stable(state_q));

  assert_open_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_OPEN) |=> (state_q == ST_OPEN));

  assert_err_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ERR) |=> (state_q == ST_ERR));

  assert_miss_to_err_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_i && !match_i && state_q[2:0] != 3'b000) |=> (state_q == ST_ERR));

  assert_hit_advance_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_i && match_i && state_q == ST_D2) |=> (state_q == ST_D3));
endmodule

// File: rtl/seq_door_lock.sv
module seq_door_lock #(
  parameter int unsigned DIGIT_W = 4,
  parameter logic [DIGIT_W-1:0] CODE_A = 3,
  parameter logic [DIGIT_W-1:0] CODE_B = 4,
  parameter logic [DIGIT_W-1:0] CODE_C = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               new_i,
  input  logic [DIGIT_W-1:0] value_i,
  output logic               open_o,
  output logic [2:0]         step_sel_o
);
  import lock_pkg::*;

  lock_state_e        state;
  logic [DIGIT_W-1:0] expect_code;
  logic               hit;

  code_select #(
    .DIGIT_W(DIGIT_W), .CODE_A(CODE_A), .CODE_B(CODE_B), .CODE_C(CODE_C)
  ) i_select (
    .sel_i  (state[2:0]),
    .code_o (expect_code)
  );

  code_match #(.DIGIT_W(DIGIT_W)) i_match (
    .entry_i  (value_i),
    .expect_i (expect_code),
    .eq_o     (hit)
  );

  lock_ctrl i_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .new_i   (new_i),
    .match_i (hit),
    .state_o (state)
  );

  // outputs are raw state bits
  assign step_sel_o = state[2:0];
  assign open_o     = state[3];

  assert_open_closed_sel_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_o |-> (step_sel_o == 3'b000));
endmodule

// File: tb/test_seq_door_lock.sv
module test_seq_door_lock;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       new_i = 1'b0;
  logic [3:0] value_i = '0;
  logic       open_o;
  logic [2:0] step_sel_o;

  int checks = 0;
  int fails  = 0;
  int step;  // 0..2 digit step, 3 open, 4 error

  logic [3:0] combo [3];

  seq_door_lock i_seq_door_lock (
    .clk_i(clk_i), .rst_ni(rst_ni), .new_i(new_i), .value_i(value_i),
    .open_o(open_o), .step_sel_o(step_sel_o)
  );

  always #10 clk_i = ~clk_i;  // 50 MHz

  function automatic logic [2:0] exp_sel(int s);
    return (s < 3) ? 3'(1 << s) : 3'b000;
  endfunction

  task automatic check(string req);
    logic [2:0] es;
    logic       eo;
    es = exp_sel(step);
    eo = (step == 3);
    checks++;
    if (step_sel_o !== es || open_o !== eo) begin
      fails++;
      $display("FAIL %s: step_sel=%b open=%b, expected step_sel=%b open=%b",
               req, step_sel_o, open_o, es, eo);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    new_i  = 1'b0;
    step   = 0;
    #1 check("R1 during reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after reset");
  endtask

  // strobe one entry and update the model
  task automatic enter(logic [3:0] v);
    @(negedge clk_i);
    new_i   = 1'b1;
    value_i = v;
    #1 check("R7 no change before edge");
    @(negedge clk_i);
    new_i = 1'b0;
    if (step < 3) step = (v == combo[step]) ? step + 1 : 4;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    combo[0] = 4'd3; combo[1] = 4'd4; combo[2] = 4'd2;
    step = 0;

    // sweep every value at every step position after a correct prefix
    for (int k = 0; k < 3; k++) begin
      for (int v = 0; v < 16; v++) begin
        do_reset();
        for (int p = 0; p < k; p++) begin
          enter(combo[p]);
          check("R4 prefix advance, R2 select");
        end
        enter(4'(v));
        if (step == 4)      check("R5 mismatch to error");
        else if (step == 3) check("R6 open after third digit");
        else                check("R4 match advances");
        // idle cycles with garbage on value_i
        @(negedge clk_i);
        value_i = 4'(v + 5);
        repeat (2) @(negedge clk_i);
        check("R3 hold without strobe");
        // extra entries: correct next digit if any, else anything
        enter((step < 3) ? combo[step] : 4'(v));
        if (step >= 3) check("R5 R6 sticky after entry");
        else           check("R4 further advance");
      end
    end

    // error then the correct digits: stays closed
    do_reset();
    enter(4'd9);
    check("R5 wrong first digit");
    for (int p = 0; p < 3; p++) enter(combo[p]);
    check("R5 error ignores correct code");

    // open, then many entries
    do_reset();
    for (int p = 0; p < 3; p++) enter(combo[p]);
    check("R6 opened");
    for (int e = 0; e < 6; e++) enter(4'(e));
    check("R6 stays open");
    do_reset();
    check("R1 reset closes open lock");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule